// File: doc/BRIEF.md
# Two-Stage Rule Dispatch Controller

This controller sits between a header classifier and a payload pattern matcher in a packet inspection pipeline. For each packet, the header classifier reports whether some header rule matched and, if so, which one. Each header rule owns a run of payload patterns in a pattern buffer. A rule table, looked up at the moment the header result is accepted, gives the first pattern index and the number of patterns in that run. The controller then copies exactly that run into the payload matcher, one write transaction per pattern. It starts the payload scan and finally emits one result per packet.

The header side and the payload side overlap. Accepted header results wait in a small staging queue of packet descriptors, so the classifier can work on packet N+1 while the patterns for packet N are being written or scanned. When the queue is full, the header side is stalled. A packet with no header match skips loading and scanning entirely and reports a miss.

Top module: `rdc_dispatch_ctrl`

## Requirements
- R1: `hdr_ready` is low exactly when the staging queue holds `STAGE_DEPTH` descriptors. A header result is taken only in a cycle where `hdr_valid` and `hdr_ready` are both high.
- R2: `tbl_idx` always equals `hdr_rule`. `tbl_start` and `tbl_count` are sampled in the cycle the header result is taken.
- R3: Results appear in the order in which header results were taken, one result per taken header result.
- R4: A header result with `hdr_hit` low causes no pattern write and no scan start. Its result has `res_hdr_hit`, `res_pay_hit`, `res_rule` and `res_addr` all zero.
- R5: A matched rule with count N produces N write transactions. Transaction j drives `pm_wr_slot` = j, and each is held with `pm_wr_en` high for `WR_BEATS` consecutive cycles. The first one begins the cycle after the descriptor leaves the queue.
- R6: During a write, `pbuf_addr` = start + j (modulo 2^`IDX_W`) and `pm_wr_data` equals `pbuf_data`.
- R7: `pm_scan_start` is a one-cycle pulse in the cycle after the last write beat. For a matched rule with count 0, it comes in the cycle after the descriptor leaves the queue. It never coincides with `pm_wr_en`.
- R8: `pm_scan_done` is ignored in the cycle of `pm_scan_start`. The first later cycle with `pm_scan_done` high ends the scan, and `res_valid` pulses for one cycle in the next cycle.
- R9: A result carries the matched rule index in `res_rule`, the sampled `pm_hit` in `res_pay_hit`, and in `res_addr` either start + `pm_hit_slot` (on a payload hit) or zero (otherwise).
- R10: Header results are still taken while patterns are being written or scanned for an earlier packet.
- R11: After reset, `hdr_ready` is high and `pm_wr_en`, `pm_scan_start` and `res_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hdr_valid | input | 1 | Header result present |
| hdr_ready | output | 1 | Staging queue can take a header result |
| hdr_hit | input | 1 | Some header rule matched |
| hdr_rule | input | RULE_W | Index of the matched header rule |
| tbl_idx | output | RULE_W | Rule table lookup index |
| tbl_start | input | IDX_W | First pattern index of the looked-up rule |
| tbl_count | input | CNT_W | Number of patterns of the looked-up rule |
| pbuf_addr | output | IDX_W | Pattern buffer read index |
| pbuf_data | input | PAT_W | Pattern buffer read data |
| pm_wr_en | output | 1 | Pattern write into the payload matcher |
| pm_wr_slot | output | SLOT_W | Matcher slot being written |
| pm_wr_data | output | PAT_W | Pattern being written |
| pm_scan_start | output | 1 | Start payload scan |
| pm_scan_done | input | 1 | Payload scan finished |
| pm_hit | input | 1 | Payload scan found a pattern |
| pm_hit_slot | input | SLOT_W | Matcher slot that hit |
| res_valid | output | 1 | Per-packet result strobe |
| res_rule | output | RULE_W | Header rule index of the packet |
| res_hdr_hit | output | 1 | Header stage matched |
| res_pay_hit | output | 1 | Payload stage matched |
| res_addr | output | IDX_W | Pattern buffer index of the payload hit |

## Verification
Two things can happen in the same cycle: a header result entering the staging queue, and the controller taking a descriptor out of it (or running a load or scan for an older packet). The bench provokes this by presenting header results back to back while multi-pattern loads run, which keeps the queue full and then lets it drain one slot at a time. It also presents bursty arrivals that reach the queue just as a result is being reported. A behavioural queue model in the bench predicts `hdr_ready`, every write beat, the scan pulse and every result field on every clock, so a lost, duplicated or reordered descriptor in a same-cycle push and pop shows up as a field mismatch.

// File: rtl/rdc_pkg.sv
package rdc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAIT_HDR,
      ST_LOAD_PATTERNS,
      ST_SCAN,
      ST_REPORT
   } rdc_state_e;

endpackage

// File: rtl/rdc_stage_queue.sv
module rdc_stage_queue #(
   parameter int DW    = 8,
   parameter int DEPTH = 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          push,
   input  logic [DW-1:0] push_data,
   input  logic          pop,
   output logic          full,
   output logic          empty,
   output logic [DW-1:0] head
);

   generate
      if (DEPTH == 1) begin : g_single
         logic          vld;
         logic [DW-1:0] data;

         always_ff @(posedge clk) begin
            if (rst) begin
               vld <= 1'b0;
            end else if (pop && vld) begin
               vld <= 1'b0;
            end else if (push && !vld) begin
               vld <= 1'b1;
            end
         end

         always_ff @(posedge clk) begin
            if (push && !vld) data <= push_data;
         end

         assign full  = vld;
         assign empty = !vld;
         assign head  = data;
      end else begin : g_ring
         localparam int PW = $clog2(DEPTH);
         localparam int CW = $clog2(DEPTH + 1);

         logic [DW-1:0] mem [DEPTH];
         logic [PW-1:0] wp, rp;
         logic [CW-1:0] occ;
         logic          do_push, do_pop;

         assign do_push = push && (occ != CW'(DEPTH));
         assign do_pop  = pop && (occ != '0);

         always_ff @(posedge clk) begin
            if (rst) begin
               wp  <= '0;
               rp  <= '0;
               occ <= '0;
            end else begin
               if (do_push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
               if (do_pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
               occ <= occ + CW'(do_push) - CW'(do_pop);
            end
         end

         always_ff @(posedge clk) begin
            if (do_push) mem[wp] <= push_data;
         end

         assign full  = (occ == CW'(DEPTH));
         assign empty = (occ == '0);
         assign head  = mem[rp];
      end
   endgenerate

endmodule

// File: rtl/rdc_load_seq.sv
module rdc_load_seq #(
   parameter int IDX_W  = 10,
   parameter int CNT_W  = 10,
   parameter int SLOT_W = 10,
   parameter int BEATS  = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [IDX_W-1:0]  start_idx,
   input  logic [CNT_W-1:0]  count,
   output logic              wr_en,
   output logic [SLOT_W-1:0] slot,
   output logic [IDX_W-1:0]  pat_idx,
   output logic              done
);

   localparam int BW = (BEATS > 1) ? $clog2(BEATS) : 1;

   logic             active;
   logic [BW-1:0]    beat;
   logic [CNT_W-1:0] entry;
   logic [CNT_W-1:0] total;
   logic [IDX_W-1:0] base;
   logic             last_beat, last_entry;

   assign last_beat  = (beat == BW'(BEATS - 1));
   assign last_entry = (entry == total - 1'b1);
   assign done       = active && last_beat && last_entry;

   always_ff @(posedge clk) begin
      if (rst) begin
         active <= 1'b0;
         beat   <= '0;
         entry  <= '0;
         total  <= '0;
         base   <= '0;
      end else if (start) begin
         active <= (count != '0);
         beat   <= '0;
         entry  <= '0;
         total  <= count;
         base   <= start_idx;
      end else if (active) begin
         if (last_beat) begin
            beat <= '0;
            if (last_entry) active <= 1'b0;
            else            entry  <= entry + 1'b1;
         end else begin
            beat <= beat + 1'b1;
         end
      end
   end

   assign wr_en   = active;
   assign slot    = SLOT_W'(entry);
   assign pat_idx = base + IDX_W'(entry);

endmodule

// File: rtl/rdc_dispatch_ctrl.sv
module rdc_dispatch_ctrl
   import rdc_pkg::*;
#(
   parameter int RULE_W      = 7,
   parameter int IDX_W       = 10,
   parameter int CNT_W       = 10,
   parameter int SLOT_W      = 10,
   parameter int PAT_W       = 160,
   parameter int WR_BEATS    = 16,
   parameter int STAGE_DEPTH = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              hdr_valid,
   output logic              hdr_ready,
   input  logic              hdr_hit,
   input  logic [RULE_W-1:0] hdr_rule,
   output logic [RULE_W-1:0] tbl_idx,
   input  logic [IDX_W-1:0]  tbl_start,
   input  logic [CNT_W-1:0]  tbl_count,
   output logic [IDX_W-1:0]  pbuf_addr,
   input  logic [PAT_W-1:0]  pbuf_data,
   output logic              pm_wr_en,
   output logic [SLOT_W-1:0] pm_wr_slot,
   output logic [PAT_W-1:0]  pm_wr_data,
   output logic              pm_scan_start,
   input  logic              pm_scan_done,
   input  logic              pm_hit,
   input  logic [SLOT_W-1:0] pm_hit_slot,
   output logic              res_valid,
   output logic [RULE_W-1:0] res_rule,
   output logic              res_hdr_hit,
   output logic              res_pay_hit,
   output logic [IDX_W-1:0]  res_addr
);

   localparam int DW = 1 + RULE_W + IDX_W + CNT_W;

   generate
      if (STAGE_DEPTH < 1) begin : g_bad_depth
         $error("rdc_dispatch_ctrl: STAGE_DEPTH must be at least 1");
      end
      if (WR_BEATS < 1) begin : g_bad_beats
         $error("rdc_dispatch_ctrl: WR_BEATS must be at least 1");
      end
      if (SLOT_W < CNT_W) begin : g_bad_slot
         $error("rdc_dispatch_ctrl: SLOT_W must cover CNT_W");
      end
      if (PAT_W < 1 || RULE_W < 1 || IDX_W < 1) begin : g_bad_width
         $error("rdc_dispatch_ctrl: widths must be positive");
      end
   endgenerate

   rdc_state_e        state;
   logic              q_full, q_empty, q_pop, q_push;
   logic [DW-1:0]     q_in, q_head;
   logic              h_hit;
   logic [RULE_W-1:0] h_rule;
   logic [IDX_W-1:0]  h_start;
   logic [CNT_W-1:0]  h_cnt;
   logic              seq_start, seq_done;
   logic              scan_issued;
   logic              cur_hit;
   logic [RULE_W-1:0] cur_rule;
   logic [IDX_W-1:0]  cur_start;
   logic              r_pay_hit;
   logic [IDX_W-1:0]  r_addr;

   // header side: lookup and staging
   assign tbl_idx   = hdr_rule;
   assign hdr_ready = !q_full;
   assign q_push    = hdr_valid && !q_full;
   assign q_in      = {hdr_hit, (hdr_hit ? hdr_rule : {RULE_W{1'b0}}), tbl_start, tbl_count};

   rdc_stage_queue #(
      .DW    (DW),
      .DEPTH (STAGE_DEPTH)
   ) i_queue (
      .clk       (clk),
      .rst       (rst),
      .push      (q_push),
      .push_data (q_in),
      .pop       (q_pop),
      .full      (q_full),
      .empty     (q_empty),
      .head      (q_head)
   );

   assign {h_hit, h_rule, h_start, h_cnt} = q_head;
   assign q_pop     = (state == ST_WAIT_HDR) && !q_empty;
   assign seq_start = q_pop && h_hit && (h_cnt != '0);

   // payload side: pattern copy
   rdc_load_seq #(
      .IDX_W  (IDX_W),
      .CNT_W  (CNT_W),
      .SLOT_W (SLOT_W),
      .BEATS  (WR_BEATS)
   ) i_load (
      .clk       (clk),
      .rst       (rst),
      .start     (seq_start),
      .start_idx (h_start),
      .count     (h_cnt),
      .wr_en     (pm_wr_en),
      .slot      (pm_wr_slot),
      .pat_idx   (pbuf_addr),
      .done      (seq_done)
   );

   assign pm_wr_data = pbuf_data;

   // sequencing
   always_ff @(posedge clk) begin
      if (rst) begin
         state       <= ST_IDLE;
         scan_issued <= 1'b0;
         cur_hit     <= 1'b0;
         cur_rule    <= '0;
         cur_start   <= '0;
         r_pay_hit   <= 1'b0;
         r_addr      <= '0;
      end else begin
         unique case (state)
            ST_IDLE: state <= ST_WAIT_HDR;
            ST_WAIT_HDR: begin
               if (q_pop) begin
                  cur_hit     <= h_hit;
                  cur_rule    <= h_rule;
                  cur_start   <= h_start;
                  r_pay_hit   <= 1'b0;
                  r_addr      <= '0;
                  scan_issued <= 1'b0;
                  if (!h_hit)              state <= ST_REPORT;
                  else if (h_cnt == '0)    state <= ST_SCAN;
                  else                     state <= ST_LOAD_PATTERNS;
               end
            end
            ST_LOAD_PATTERNS: begin
               if (seq_done) state <= ST_SCAN;
            end
            ST_SCAN: begin
               if (!scan_issued) begin
                  scan_issued <= 1'b1;
               end else if (pm_scan_done) begin
                  r_pay_hit <= pm_hit;
                  r_addr    <= pm_hit ? (cur_start + IDX_W'(pm_hit_slot)) : '0;
                  state     <= ST_REPORT;
               end
            end
            ST_REPORT: state <= ST_WAIT_HDR;
            default:   state <= ST_IDLE;
         endcase
      end
   end

   assign pm_scan_start = (state == ST_SCAN) && !scan_issued;
   assign res_valid     = (state == ST_REPORT);
   assign res_rule      = cur_rule;
   assign res_hdr_hit   = cur_hit;
   assign res_pay_hit   = r_pay_hit;
   assign res_addr      = r_addr;

endmodule

// File: rtl/rdc_dispatch_checker.sv
module rdc_dispatch_checker #(
   parameter int RULE_W   = 7,
   parameter int IDX_W    = 10,
   parameter int SLOT_W   = 10,
   parameter int WR_BEATS = 16
) (
   input logic              clk,
   input logic              rst,
   input logic              pm_wr_en,
   input logic [SLOT_W-1:0] pm_wr_slot,
   input logic              pm_scan_start,
   input logic              res_valid,
   input logic [RULE_W-1:0] res_rule,
   input logic              res_hdr_hit,
   input logic              res_pay_hit,
   input logic [IDX_W-1:0]  res_addr
);

   logic [31:0]       run;
   logic [SLOT_W-1:0] last_slot;

   always_ff @(posedge clk) begin
      if (rst) begin
         run       <= '0;
         last_slot <= '0;
      end else if (pm_wr_en) begin
         if (run != 0 && pm_wr_slot == last_slot) run <= run + 1;
         else                                     run <= 32'd1;
         last_slot <= pm_wr_slot;
      end else begin
         run <= '0;
      end
   end

   p_wr_scan_excl_r7: assert property (@(posedge clk) disable iff (rst)
      !(pm_wr_en && pm_scan_start));

   p_scan_pulse_r7: assert property (@(posedge clk) disable iff (rst)
      pm_scan_start |=> !pm_scan_start);

   p_res_pulse_r8: assert property (@(posedge clk) disable iff (rst)
      res_valid |=> !res_valid);

   p_res_idle_side_r8: assert property (@(posedge clk) disable iff (rst)
      res_valid |-> (!pm_wr_en && !pm_scan_start));

   p_slot_step_r5: assert property (@(posedge clk) disable iff (rst)
      (pm_wr_en && $past(pm_wr_en)) |->
         (pm_wr_slot == $past(pm_wr_slot) || pm_wr_slot == SLOT_W'($past(pm_wr_slot) + 1'b1)));

   p_beat_limit_r5: assert property (@(posedge clk) disable iff (rst)
      run <= WR_BEATS);

   p_miss_clean_r4: assert property (@(posedge clk) disable iff (rst)
      (res_valid && !res_hdr_hit) |-> (!res_pay_hit && res_addr == '0 && res_rule == '0));

endmodule

bind rdc_dispatch_ctrl rdc_dispatch_checker #(
   .RULE_W   (RULE_W),
   .IDX_W    (IDX_W),
   .SLOT_W   (SLOT_W),
   .WR_BEATS (WR_BEATS)
) i_checker (
   .clk           (clk),
   .rst           (rst),
   .pm_wr_en      (pm_wr_en),
   .pm_wr_slot    (pm_wr_slot),
   .pm_scan_start (pm_scan_start),
   .res_valid     (res_valid),
   .res_rule      (res_rule),
   .res_hdr_hit   (res_hdr_hit),
   .res_pay_hit   (res_pay_hit),
   .res_addr      (res_addr)
);

// File: tb/test_rdc_dispatch_ctrl.sv
`timescale 1ns/1ps
module test_rdc_dispatch_ctrl;

   localparam int RULE_W = 7;
   localparam int IDX_W  = 10;
   localparam int CNT_W  = 10;
   localparam int SLOT_W = 10;
   localparam int PAT_W  = 160;
   localparam int BEATS  = 16;
   localparam int DEPTH  = 2;
   localparam int NPKT   = 24;
   localparam int WDOG   = 20000;

   logic              clk = 1'b0;
   logic              rst;
   logic              hdr_valid, hdr_ready, hdr_hit;
   logic [RULE_W-1:0] hdr_rule, tbl_idx;
   logic [IDX_W-1:0]  tbl_start, pbuf_addr, res_addr;
   logic [CNT_W-1:0]  tbl_count;
   logic [PAT_W-1:0]  pbuf_data, pm_wr_data;
   logic              pm_wr_en, pm_scan_start, pm_scan_done, pm_hit;
   logic [SLOT_W-1:0] pm_wr_slot, pm_hit_slot;
   logic              res_valid, res_hdr_hit, res_pay_hit;
   logic [RULE_W-1:0] res_rule;

   always #2.5 clk = ~clk;

   function automatic int rule_of(int i);  return (i * 7 + 2) % 16; endfunction
   function automatic int hit_of(int i);   return (i % 4 != 2) ? 1 : 0; endfunction
   function automatic int cnt_of(int r);   return (r == 9) ? 0 : (r % 3) + 1; endfunction
   function automatic int start_of(int r); return r * 16 + 1; endfunction
   function automatic logic [PAT_W-1:0] pat_of(int a);
      logic [31:0] w;
      w = 32'(a) * 32'h9E37_79B1;
      return {5{w}};
   endfunction

   // rule table and pattern buffer stand-ins
   assign tbl_start = IDX_W'(start_of(int'(tbl_idx)));
   assign tbl_count = CNT_W'(cnt_of(int'(tbl_idx)));
   assign pbuf_data = pat_of(int'(pbuf_addr));

   rdc_dispatch_ctrl #(
      .RULE_W(RULE_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .SLOT_W(SLOT_W),
      .PAT_W(PAT_W), .WR_BEATS(BEATS), .STAGE_DEPTH(DEPTH)
   ) i_rdc_dispatch_ctrl (
      .clk(clk), .rst(rst),
      .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_hit(hdr_hit), .hdr_rule(hdr_rule),
      .tbl_idx(tbl_idx), .tbl_start(tbl_start), .tbl_count(tbl_count),
      .pbuf_addr(pbuf_addr), .pbuf_data(pbuf_data),
      .pm_wr_en(pm_wr_en), .pm_wr_slot(pm_wr_slot), .pm_wr_data(pm_wr_data),
      .pm_scan_start(pm_scan_start), .pm_scan_done(pm_scan_done),
      .pm_hit(pm_hit), .pm_hit_slot(pm_hit_slot),
      .res_valid(res_valid), .res_rule(res_rule), .res_hdr_hit(res_hdr_hit),
      .res_pay_hit(res_pay_hit), .res_addr(res_addr)
   );

   // ---------------- behavioural reference model ----------------
   typedef struct { int hit; int rule; int start; int cnt; } desc_t;
   desc_t mq[$];
   desc_t cur;
   int m_state;          // 0 idle, 1 waiting, 2 loading, 3 scanning, 4 reporting
   int m_j, m_beat, m_issued, m_wait;
   int m_pay, m_addr;
   int m_took, overlap_cnt, full_cnt;

   always @(posedge clk) begin
      if (rst) begin
         mq.delete();
         m_state = 0; m_j = 0; m_beat = 0; m_issued = 0; m_wait = 0;
         m_pay = 0; m_addr = 0; m_took = 0;
         cur = '{0, 0, 0, 0};
      end else begin
         int  old_size;
         bit  push_now;
         desc_t nd;
         old_size = mq.size();
         push_now = hdr_valid && (old_size < DEPTH);
         if (push_now && (m_state == 2 || m_state == 3)) overlap_cnt++;
         case (m_state)
            0: m_state = 1;
            1: if (old_size > 0) begin
                  cur = mq.pop_front();
                  m_pay = 0; m_addr = 0; m_issued = 0; m_wait = 0;
                  m_j = 0; m_beat = 0;
                  if (cur.hit == 0)     m_state = 4;
                  else if (cur.cnt == 0) m_state = 3;
                  else                  m_state = 2;
               end
            2: if (m_beat == BEATS - 1) begin
                  m_beat = 0;
                  if (m_j == cur.cnt - 1) begin m_state = 3; m_issued = 0; m_wait = 0; end
                  else m_j++;
               end else m_beat++;
            3: if (m_issued == 0) m_issued = 1;
               else if (pm_scan_done) begin
                  m_pay  = pm_hit;
                  m_addr = pm_hit ? (cur.start + int'(pm_hit_slot)) % (1 << IDX_W) : 0;
                  m_state = 4;
               end else m_wait++;
            default: m_state = 1;
         endcase
         if (push_now) begin
            nd.hit   = hdr_hit;
            nd.rule  = hdr_hit ? int'(hdr_rule) : 0;
            nd.start = start_of(int'(hdr_rule));
            nd.cnt   = cnt_of(int'(hdr_rule));
            mq.push_back(nd);
            m_took = 1;
         end
      end
   end

   // ---------------- checking ----------------
   int tests = 0, fails = 0;
   int results_seen = 0;
   int pkt_i = 0;
   int cyc = 0;

   task automatic chk(bit ok, string what, longint act, longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   task automatic compare_cycle();
      int ew, ea;
      chk(hdr_ready == (mq.size() < DEPTH), "R1 hdr_ready", hdr_ready, mq.size() < DEPTH);
      if (mq.size() == DEPTH) full_cnt++;
      chk(tbl_idx == hdr_rule, "R2 tbl_idx follows hdr_rule", tbl_idx, hdr_rule);
      ew = (m_state == 2);
      chk(pm_wr_en == ew, "R5 pm_wr_en", pm_wr_en, ew);
      if (ew != 0) begin
         ea = (cur.start + m_j) % (1 << IDX_W);
         chk(int'(pm_wr_slot) == m_j, "R5 pm_wr_slot", pm_wr_slot, m_j);
         chk(int'(pbuf_addr) == ea, "R6 pbuf_addr", pbuf_addr, ea);
         chk(pm_wr_data == pat_of(ea), "R6 pm_wr_data", pm_wr_data[31:0], pat_of(ea) & 32'hFFFF_FFFF);
      end
      chk(pm_scan_start == (m_state == 3 && m_issued == 0), "R7 pm_scan_start",
          pm_scan_start, (m_state == 3 && m_issued == 0));
      chk(res_valid == (m_state == 4), "R8 res_valid", res_valid, m_state == 4);
      if (m_state == 4) begin
         results_seen++;
         chk(int'(res_rule) == cur.rule, "R3 res_rule order", res_rule, cur.rule);
         chk(int'(res_hdr_hit) == cur.hit, "R4 res_hdr_hit", res_hdr_hit, cur.hit);
         chk(int'(res_pay_hit) == m_pay, "R9 res_pay_hit", res_pay_hit, m_pay);
         chk(int'(res_addr) == m_addr, "R9 res_addr", res_addr, m_addr);
      end
   endtask

   task automatic drive_cycle();
      int lat;
      if (m_took != 0) begin pkt_i++; m_took = 0; end
      hdr_valid = (pkt_i < NPKT) && !(pkt_i >= 14 && (cyc % 40) < 30);
      hdr_hit   = (pkt_i < NPKT) ? hit_of(pkt_i) != 0 : 1'b0;
      hdr_rule  = (pkt_i < NPKT) ? RULE_W'(rule_of(pkt_i)) : '0;
      lat = cur.rule % 3;
      pm_scan_done = 1'b0; pm_hit = 1'b0; pm_hit_slot = '0;
      if (m_state == 3 && m_issued == 0) begin
         // decoy in the start cycle, must be ignored (R8)
         pm_scan_done = 1'b1; pm_hit = 1'b1; pm_hit_slot = SLOT_W'(3);
      end else if (m_state == 3) begin
         pm_scan_done = (m_wait == lat);
         pm_hit       = (cur.rule % 2) == 1;
         pm_hit_slot  = SLOT_W'((cur.cnt > 0) ? cur.cnt - 1 : 0);
      end
   endtask

   initial begin
      rst = 1'b1;
      hdr_valid = 1'b0; hdr_hit = 1'b0; hdr_rule = '0;
      pm_scan_done = 1'b0; pm_hit = 1'b0; pm_hit_slot = '0;
      overlap_cnt = 0; full_cnt = 0;
      repeat (4) @(negedge clk);
      rst = 1'b0;
      // R11 reset state
      chk(hdr_ready == 1'b1, "R11 hdr_ready after reset", hdr_ready, 1);
      chk(pm_wr_en == 1'b0, "R11 pm_wr_en after reset", pm_wr_en, 0);
      chk(pm_scan_start == 1'b0, "R11 pm_scan_start after reset", pm_scan_start, 0);
      chk(res_valid == 1'b0, "R11 res_valid after reset", res_valid, 0);
      while (!(results_seen == NPKT && m_state == 1 && mq.size() == 0) && cyc < WDOG) begin
         drive_cycle();
         @(negedge clk);
         cyc++;
         compare_cycle();
      end
      if (cyc >= WDOG) chk(1'b0, "watchdog expired", cyc, WDOG);
      chk(results_seen == NPKT, "R3 one result per packet", results_seen, NPKT);
      chk(overlap_cnt > 0, "R10 header taken during load or scan", overlap_cnt, 1);
      chk(full_cnt > 0, "R1 backpressure observed", full_cnt, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule